// File: doc/BRIEF.md
# Serial Command Bridge with One-Frame-Lagged Readback

The bridge connects a host register port to a register bank that sits behind a serial link. The host writes 32-bit command words into a command queue. A shift engine takes one word at a time and sends it out most-significant bit first, one bit per clock, under a frame strobe. In the same 32 cycles it samples a 32-bit word from the far end. Every frame pushes exactly one captured word into a response queue, whatever the command was.

The far end answers a read during the frame that follows the read. The word captured during the read's own frame is therefore a placeholder. Software discards it and sends one trailing no-operation command to collect the last result.

The bridge does not decode command words. Its bench uses this layout: bits 31:30 zero, bits 29:26 opcode (0 no-op, 1 read, 2 write), bits 25:16 register address, bits 15:0 write data. A read result comes back in bits 15:0.

A small alarm unit records rising edges on the alarm inputs in write-one-to-clear status bits. It drives an interrupt from the bits whose mask bit is 0.

Top module: `cmd_serial_bridge`

## Requirements
- R1: A host write to address 0 appends host_wdata to the command queue. When the queue already holds FIFO_DEPTH words, the write is dropped and sticky status bit 4 (command overflow) is set.
- R2: A frame lasts exactly 32 cycles with ser_frame high throughout. ser_mosi carries the command word MSB first, starting in the first frame cycle. ser_miso is sampled on each of the 32 rising edges, MSB first.
- R3: Each frame pushes exactly one word, the 32 bits sampled from ser_miso, into the response queue. Responses keep frame order and are independent of the opcode.
- R4: A frame starts only while the command queue is non-empty and the response queue is not full. A full response queue stalls further frames until the host pops a word.
- R5: A host read of address 1 returns the oldest response word and removes it. A read while the response queue is empty returns 0 and sets sticky status bit 5 (response underflow).
- R6: Status, read at address 2, has these bits: 0 command queue empty, 1 command queue full, 2 response queue empty, 3 response queue full, 4 overflow, 5 underflow, 6 frame in progress. Writing 1 to bit 4 or bit 5 clears that bit.
- R7: Alarm status, at address 3, bit i is set by a rising edge on alarm_in[i] and cleared by writing 1 to it. A level held high does not set the bit again.
- R8: Alarm mask, at address 4, bit i set to 1 disables alarm i. irq is the OR of the alarm status bits whose mask bit is 0. Writing 7Eh enables only alarm 0, and writing 7Fh masks every alarm.
- R9: Reset empties both queues, clears every status bit and sets every alarm mask bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe; pops the response queue when it addresses address 1 |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| ser_frame | output | 1 | High for the 32 cycles of a frame |
| ser_mosi | output | 1 | Serial command bit |
| ser_miso | input | 1 | Serial response bit |
| alarm_in | input | NUM_ALARMS | Alarm levels from the far end |
| irq | output | 1 | Interrupt from unmasked alarm status bits |

## Verification
The bench builds the bridge with its default parameters: 32-bit words, queues 16 entries deep and seven alarms. At this depth the response queue fills after only sixteen frames, so the stall at a full response queue is easy to reach. A command queue full behind that stall, and a dropped seventeenth write, are then reached in a few hundred cycles. A far-end model returns each read one frame late, and a scoreboard predicts every popped word from a separate register image. Seven alarms cover the mask patterns 7Eh and 7Fh exactly.

// File: rtl/cmd_bridge_pkg.sv
package cmd_bridge_pkg;

  // Host register map
  localparam logic [2:0] ADR_CMD      = 3'd0;
  localparam logic [2:0] ADR_RESP     = 3'd1;
  localparam logic [2:0] ADR_STATUS   = 3'd2;
  localparam logic [2:0] ADR_ALM_STS  = 3'd3;
  localparam logic [2:0] ADR_ALM_MASK = 3'd4;

  // Status bit positions
  localparam int ST_CMD_EMPTY = 0;
  localparam int ST_CMD_FULL  = 1;
  localparam int ST_RSP_EMPTY = 2;
  localparam int ST_RSP_FULL  = 3;
  localparam int ST_OVF       = 4;
  localparam int ST_UDF       = 5;
  localparam int ST_BUSY      = 6;

  // Command opcodes used by the far end
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_READ  = 4'd1,
    OP_WRITE = 4'd2
  } cmd_op_e;

endpackage

// File: rtl/bridge_fifo.sv
module bridge_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = bump(wr_ptr_q);
    if (pop)  rd_ptr_d = bump(rd_ptr_q);
    if (push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_data;
  end

  // R1: callers never push into a full queue
  assert_push_not_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: callers never pop an empty queue
  assert_pop_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/bridge_shifter.sv
module bridge_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_avail,
  input  logic [W-1:0] cmd_word,
  input  logic         rsp_space,
  output logic         cmd_take,
  output logic         rsp_push,
  output logic [W-1:0] rsp_word,
  output logic         frame,
  output logic         mosi,
  input  logic         miso
);
  localparam int CNT_W = $clog2(W);

  logic             busy_q, busy_d;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, last;

  assign start    = !busy_q && cmd_avail && rsp_space;
  assign last     = busy_q && (cnt_q == CNT_W'(W - 1));
  assign cmd_take = start;
  assign rsp_push = last;
  assign rsp_word = {rx_q[W-2:0], miso};
  assign frame    = busy_q;
  assign mosi     = tx_q[W-1];

  always_comb begin
    busy_d = busy_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      tx_d   = cmd_word;
      cnt_d  = '0;
    end else if (busy_q) begin
      tx_d  = {tx_q[W-2:0], 1'b0};
      rx_d  = {rx_q[W-2:0], miso};
      cnt_d = cnt_q + CNT_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (start || busy_q) begin
        tx_q  <= tx_d;
        rx_q  <= rx_d;
        cnt_q <= cnt_d;
      end
    end
  end

  // R2: a frame ends only after its final bit position
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame) |-> $past(cnt_q) == CNT_W'(W - 1));
  // R4: a frame begins only with a command waiting and response room
  assert_start_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> $past(cmd_avail) && $past(rsp_space));
  // R3: the single response push marks the close of a frame
  assert_push_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_push |=> !frame);

endmodule

// File: rtl/bridge_alarms.sv
module bridge_alarms #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alarm_in,
  input  logic         sts_w1c,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] sts,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] sts_d, mask_d, rise, clr;

  assign rise = alarm_in & ~lvl_q;
  assign clr  = sts_w1c ? wdata : '0;
  assign irq  = |(sts & ~mask);

  always_comb begin
    sts_d  = (sts & ~clr) | rise;
    mask_d = mask_we ? wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      sts   <= '0;
      mask  <= '1;
    end else begin
      lvl_q <= alarm_in;
      sts   <= sts_d;
      if (mask_we) mask <= mask_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7: an edge on an alarm line leaves its status bit set
    assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_in[i] && !lvl_q[i]) |=> sts[i]);
  end

  // R8: with every alarm masked the interrupt stays low
  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

endmodule

// File: rtl/cmd_serial_bridge.sv
module cmd_serial_bridge
  import cmd_bridge_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_ALARMS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic                  host_re,
  input  logic [2:0]            host_addr,
  input  logic [WORD_W-1:0]     host_wdata,
  output logic [WORD_W-1:0]     host_rdata,
  output logic                  ser_frame,
  output logic                  ser_mosi,
  input  logic                  ser_miso,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  output logic                  irq
);
  logic cmd_push, cmd_pop, cmd_empty, cmd_full;
  logic rsp_push, rsp_pop, rsp_empty, rsp_full;
  logic [WORD_W-1:0] cmd_head, rsp_head, rsp_word;
  logic wr_cmd, rd_rsp;
  logic ovf_q, ovf_d, udf_q, udf_d;
  logic [NUM_ALARMS-1:0] alm_sts, alm_mask;
  logic [6:0] status;

  assign wr_cmd   = host_we && (host_addr == ADR_CMD);
  assign rd_rsp   = host_re && (host_addr == ADR_RESP);
  assign cmd_push = wr_cmd && !cmd_full;
  assign rsp_pop  = rd_rsp && !rsp_empty;

  bridge_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .push_data(host_wdata),
    .pop(cmd_pop), .head(cmd_head), .empty(cmd_empty), .full(cmd_full));

  bridge_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rsp_q (
    .clk(clk), .rst_n(rst_n), .push(rsp_push), .push_data(rsp_word),
    .pop(rsp_pop), .head(rsp_head), .empty(rsp_empty), .full(rsp_full));

  bridge_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cmd_avail(!cmd_empty), .cmd_word(cmd_head),
    .rsp_space(!rsp_full), .cmd_take(cmd_pop), .rsp_push(rsp_push),
    .rsp_word(rsp_word), .frame(ser_frame), .mosi(ser_mosi), .miso(ser_miso));

  bridge_alarms #(.N(NUM_ALARMS)) u_alm (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in),
    .sts_w1c(host_we && (host_addr == ADR_ALM_STS)),
    .mask_we(host_we && (host_addr == ADR_ALM_MASK)),
    .wdata(host_wdata[NUM_ALARMS-1:0]),
    .sts(alm_sts), .mask(alm_mask), .irq(irq));

  // Sticky error bits: set wins over a same-cycle clear
  always_comb begin
    ovf_d = ovf_q;
    udf_d = udf_q;
    if (host_we && (host_addr == ADR_STATUS)) begin
      if (host_wdata[ST_OVF]) ovf_d = 1'b0;
      if (host_wdata[ST_UDF]) udf_d = 1'b0;
    end
    if (wr_cmd && cmd_full)  ovf_d = 1'b1;
    if (rd_rsp && rsp_empty) udf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  always_comb begin
    status = '0;
    status[ST_CMD_EMPTY] = cmd_empty;
    status[ST_CMD_FULL]  = cmd_full;
    status[ST_RSP_EMPTY] = rsp_empty;
    status[ST_RSP_FULL]  = rsp_full;
    status[ST_OVF]       = ovf_q;
    status[ST_UDF]       = udf_q;
    status[ST_BUSY]      = ser_frame;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADR_RESP:     host_rdata = rsp_empty ? '0 : rsp_head;
      ADR_STATUS:   host_rdata = WORD_W'(status);
      ADR_ALM_STS:  host_rdata = WORD_W'(alm_sts);
      ADR_ALM_MASK: host_rdata = WORD_W'(alm_mask);
      default:      host_rdata = '0;
    endcase
  end

  // R1: a write that meets a full command queue leaves the overflow flag set
  assert_overflow_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd_full) |=> ovf_q);
  // R5: an empty-queue pop reads zero and flags underflow
  assert_underflow_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp && rsp_empty) |-> (host_rdata == '0) ##1 udf_q);

endmodule

// File: tb/cmd_serial_bridge_tb.sv
`timescale 1ns/1ps
module cmd_serial_bridge_tb;
  import cmd_bridge_pkg::*;

  localparam int W = 32;
  localparam int D = 16;
  localparam int NA = 7;
  localparam logic [31:0] DUMMY = 32'hBAD0_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic host_we, host_re;
  logic [2:0] host_addr;
  logic [W-1:0] host_wdata, host_rdata;
  logic ser_frame, ser_mosi, ser_miso;
  logic [NA-1:0] alarm_in;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmd_serial_bridge #(.WORD_W(W), .FIFO_DEPTH(D), .NUM_ALARMS(NA)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ser_frame(ser_frame), .ser_mosi(ser_mosi), .ser_miso(ser_miso),
    .alarm_in(alarm_in), .irq(irq));

  // Scoreboard queues and bench-side register image
  logic [31:0] exp_cmd_q[$];
  logic [31:0] exp_rsp_q[$];
  logic [31:0] pending;
  logic [15:0] img [1024];

  // Far-end register bank
  logic [15:0] fe_regs [1024];
  logic [31:0] fe_rsp, fe_cap;
  int fe_k;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Far end: answers a read one frame later; also acts as the command monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      fe_k = 0;
    end else if (ser_frame) begin
      fe_cap[31-fe_k] = ser_mosi;
      ser_miso <= fe_rsp[31-fe_k];
      if (fe_k == 31) begin
        fe_k = 0;
        if (exp_cmd_q.size() == 0) begin
          chk("R2 unexpected frame", fe_cap, 32'hFFFF_FFFF);
        end else begin
          chk("R2 serial command bits", fe_cap, exp_cmd_q.pop_front());
        end
        if (fe_cap[29:26] == OP_READ) fe_rsp = {16'h0, fe_regs[fe_cap[25:16]]};
        else fe_rsp = DUMMY;
        if (fe_cap[29:26] == OP_WRITE) fe_regs[fe_cap[25:16]] = fe_cap[15:0];
      end else begin
        fe_k = fe_k + 1;
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  // Driver: push a command and predict its frame's response
  task automatic send_cmd(input logic [3:0] op, input logic [9:0] a, input logic [15:0] d);
    logic [31:0] w;
    w = {2'b00, op, a, d};
    exp_cmd_q.push_back(w);
    exp_rsp_q.push_back(pending);
    pending = (op == OP_READ) ? {16'h0, img[a]} : DUMMY;
    if (op == OP_WRITE) img[a] = d;
    bus_wr(ADR_CMD, w);
  endtask

  // Monitor side of the response path: pop and compare
  task automatic pop_rsp(input string req);
    logic [31:0] v;
    bus_rd(ADR_RESP, v);
    if (exp_rsp_q.size() == 0) chk({req, " no expected word"}, v, 32'hFFFF_FFFF);
    else chk(req, v, exp_rsp_q.pop_front());
  endtask

  task automatic wait_status(input logic [6:0] m, input logic [6:0] v);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      bus_rd(ADR_STATUS, s);
      if ((s[6:0] & m) == v) return;
    end
    chk("status wait timeout", 32'h0, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_test();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) begin
      img[i] = '0;
      fe_regs[i] = '0;
    end
    pending = DUMMY;
    fe_rsp = DUMMY;
    fe_cap = '0;
    ser_miso = 1'b0;
    host_we = 0; host_re = 0; host_addr = '0; host_wdata = '0;
    alarm_in = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state: status bit0 and bit2 set only
    bus_rd(ADR_STATUS, v);   chk("R9 status after reset", v, 32'h05);
    bus_rd(ADR_ALM_MASK, v); chk("R9 mask after reset", v, 32'h7F);
    bus_rd(ADR_ALM_STS, v);  chk("R9 alarm status after reset", v, 32'h0);
    chk("R9 irq after reset", {31'h0, irq}, 32'h0);
    chk("R9 frame idle", {31'h0, ser_frame}, 32'h0);

    // R5 underflow and R6 write-one-to-clear
    bus_rd(ADR_RESP, v);   chk("R5 empty read value", v, 32'h0);
    bus_rd(ADR_STATUS, v); chk("R5 underflow bit5", v, 32'h25);
    bus_wr(ADR_STATUS, 32'h10);
    bus_rd(ADR_STATUS, v); chk("R6 clear of bit4 leaves bit5", v, 32'h25);
    bus_wr(ADR_STATUS, 32'h20);
    bus_rd(ADR_STATUS, v); chk("R6 bit5 cleared", v, 32'h05);

    // R3 lagged readback: write, read, trailing no-op
    send_cmd(OP_WRITE, 10'h005, 16'h1234);
    send_cmd(OP_READ, 10'h005, 16'h0);
    send_cmd(OP_NOP, 10'h0, 16'h0);
    wait_status(7'h41, 7'h01);
    bus_rd(ADR_STATUS, v); chk("R6 three words queued", v, 32'h01);
    for (int i = 0; i < 3; i++) pop_rsp("R3 lagged word");
    bus_rd(ADR_STATUS, v); chk("R6 queues drained", v, 32'h05);

    // R3 back-to-back reads at address extremes
    send_cmd(OP_WRITE, 10'h3FF, 16'hBEEF);
    send_cmd(OP_WRITE, 10'h000, 16'h0001);
    send_cmd(OP_READ, 10'h3FF, 16'h0);
    send_cmd(OP_READ, 10'h000, 16'h0);
    send_cmd(OP_READ, 10'h3FF, 16'h0);
    send_cmd(OP_NOP, 10'h0, 16'h0);
    wait_status(7'h41, 7'h01);
    for (int i = 0; i < 6; i++) pop_rsp("R3 consecutive reads");

    // R4 stall on full response queue, R1 overflow
    for (int i = 0; i < D; i++) send_cmd(OP_READ, 10'(i), 16'h0);
    wait_status(7'h49, 7'h09);
    for (int i = 0; i < D; i++) send_cmd(OP_NOP, 10'h0, 16'h0);
    bus_rd(ADR_STATUS, v); chk("R4 both queues full", v, 32'h0A);
    bus_wr(ADR_CMD, 32'h0400_0000);
    bus_rd(ADR_STATUS, v); chk("R1 overflow on dropped write", v, 32'h1A);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (ser_frame) seen++;
      end
      chk("R4 no frame while response queue full", 32'(seen), 32'h0);
    end
    for (int i = 0; i < D; i++) pop_rsp("R4 first half");
    wait_status(7'h49, 7'h09);
    for (int i = 0; i < D; i++) pop_rsp("R1 second half");
    bus_rd(ADR_STATUS, v); chk("R1 drop left 32 words only", v, 32'h15);
    bus_wr(ADR_STATUS, 32'h10);
    bus_rd(ADR_STATUS, v); chk("R6 overflow cleared", v, 32'h05);
    chk("R3 all frames seen", 32'(exp_cmd_q.size()), 32'h0);

    // R7 / R8 alarms
    @(negedge clk); alarm_in[0] = 1'b1;
    @(negedge clk);
    bus_rd(ADR_ALM_STS, v); chk("R7 edge sets bit0", v, 32'h01);
    chk("R8 masked 7Fh keeps irq low", {31'h0, irq}, 32'h0);
    bus_wr(ADR_ALM_MASK, 32'h7E);
    @(negedge clk);
    chk("R8 mask 7Eh raises irq", {31'h0, irq}, 32'h1);
    @(negedge clk); alarm_in[1] = 1'b1;
    @(negedge clk);
    bus_rd(ADR_ALM_STS, v); chk("R7 edge sets bit1", v, 32'h03);
    bus_wr(ADR_ALM_STS, 32'h01);
    repeat (3) @(negedge clk);
    bus_rd(ADR_ALM_STS, v); chk("R7 held level no re-set", v, 32'h02);
    chk("R8 only masked bit left", {31'h0, irq}, 32'h0);
    bus_wr(ADR_ALM_MASK, 32'h00);
    @(negedge clk);
    chk("R8 unmasking bit1 raises irq", {31'h0, irq}, 32'h1);
    bus_wr(ADR_ALM_STS, 32'h7F);
    @(negedge clk);
    chk("R7 clear all drops irq", {31'h0, irq}, 32'h0);

    finish_test();
  end

endmodule